// File: doc/BRIEF.md
# Truncated-Phase Sine Synthesizer

This block is a direct digital synthesis core. It keeps an N-bit phase accumulator. On every sample tick the accumulator grows by a programmable step, and it wraps modulo 2^N. The output frequency is therefore step·fs/2^N, where fs is the tick rate. The smallest non-zero frequency, which is also the frequency resolution, is fs/2^N.

Only the top P bits of the phase address an internal table. That table holds one sine period of 2^P codes, each L bits wide, and it is computed when the design elaborates. The low phase bits are dropped only from the address, so the table stays small while the frequency resolution stays that of the full N bits.

Each tick produces one registered sample for an external converter, in offset-binary form. A one-cycle valid pulse marks the new sample. The sample then holds until the next tick, which gives a staircase waveform.

A new step value written through the load port waits in a holding register. It becomes active at the next tick and never in the middle of an update. A load never disturbs the running phase.

Top module: `dds_sine_gen`

## Requirements
- R1: While reset is asserted and after it is released with no tick, `sample_out` equals 2^(L-1) (the phase-0 code) and `sample_valid` is 0.
- R2: Each clock with `sample_tick` high adds the active step to the phase modulo 2^N, so after K ticks at a constant step M the phase is K·M mod 2^N.
- R3: The sample for phase p is 2^(L-1) + round((2^(L-1)-1)·sin(2π·a/2^P)), where a = p[N-1:N-P] (the top P bits, unsigned).
- R4: `sample_valid` is high for exactly the clock cycle that follows the first rising edge after the edge that sampled the tick. The new `sample_out` appears at that same edge.
- R5: With no tick, `sample_out` holds its value and `sample_valid` stays 0.
- R6: A word presented with `tune_load` becomes the active step at the first later tick. That tick still adds the previous step, and the new word is used from the following tick on.
- R7: Loading a new word never changes the phase; the accumulation continues from the current phase.
- R8: An active step of zero, including the step left by reset, keeps the sample constant while `sample_valid` still pulses on every tick.
- R9: The phase bits below the table address still accumulate: with step 1 the table address advances once every 2^(N-P) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle sample-rate strobe |
| tune_word | input | PHASE_W | Phase step to load |
| tune_load | input | 1 | Captures `tune_word` into the holding register |
| sample_out | output | SAMPLE_W | Offset-binary sine sample |
| sample_valid | output | 1 | Pulses when a new sample is presented |

## Verification
The checks use N=12, P=8 and L=10 throughout.

A step of 16 advances the address by exactly one per tick. A sweep of more than one period with this step visits every table entry and shows that the whole table is right, including the wrap back to address 0.

A step of 1 steps the address only once every sixteen ticks. This separates true accumulation of the discarded bits from a design that adds the step straight to the address.

A step of zero, both from reset and from a later load, shows the held output alongside an active valid pulse. An odd step of 333 loaded in the middle of a run, followed by 2049 just above half scale, exercises uneven address jumps and aliasing. Because each load lands mid-run, it also shows whether the phase continues unbroken and whether the new step starts at the correct tick.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam real PI_C = 3.14159265358979323846;

  // Odd power series, accurate for |x| <= pi/2
  function automatic real sin_core(real x);
    real term;
    real sum;
    term = x;
    sum  = x;
    for (int k = 1; k <= 10; k++) begin
      term = -term * x * x / (real'(2 * k) * real'(2 * k + 1));
      sum  = sum + term;
    end
    return sum;
  endfunction

  // Offset-binary sine code for table index idx of 2^addr_w entries
  function automatic int sine_code(int idx, int addr_w, int sample_w);
    real ang;
    real s;
    real v;
    int  amp;
    int  r;
    ang = 2.0 * PI_C * real'(idx) / real'(1 << addr_w);
    if (ang > PI_C / 2.0 && ang <= 3.0 * PI_C / 2.0)
      s = sin_core(PI_C - ang);
    else if (ang > 3.0 * PI_C / 2.0)
      s = sin_core(ang - 2.0 * PI_C);
    else
      s = sin_core(ang);
    amp = (1 << (sample_w - 1)) - 1;
    v   = real'(amp) * s;
    if (v >= 0.0) r = int'($rtoi(v + 0.5));
    else          r = -int'($rtoi(-v + 0.5));
    return (1 << (sample_w - 1)) + r;
  endfunction

endpackage

// File: rtl/dds_tune_reg.sv
module dds_tune_reg #(
  parameter int PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [PHASE_W-1:0] word,
  output logic [PHASE_W-1:0] step
);

  logic [PHASE_W-1:0] hold_q, hold_d;
  logic               hold_vld_q, hold_vld_d;
  logic [PHASE_W-1:0] step_q, step_d;

  always_comb begin
    hold_d     = hold_q;
    hold_vld_d = hold_vld_q;
    step_d     = step_q;
    if (tick && hold_vld_q) begin
      step_d     = hold_q;
      hold_vld_d = 1'b0;
    end
    if (load) begin
      hold_d     = word;
      hold_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      step_q     <= '0;
    end else begin
      hold_q     <= hold_d;
      hold_vld_q <= hold_vld_d;
      step_q     <= step_d;
    end
  end

  assign step = step_q;

  assert_step_only_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(step_q));

  assert_load_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hold_vld_q);

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 12,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PHASE_W-1:0] step,
  output logic [ADDR_W-1:0]  addr,
  output logic               advanced
);

  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               adv_q;

  always_comb begin
    phase_d = phase_q;
    if (tick) phase_d = phase_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      adv_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      adv_q   <= tick;
    end
  end

  assign addr     = phase_q[PHASE_W-1 -: ADDR_W];
  assign advanced = adv_q;

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase_q == $past(phase_q) + $past(step));

  assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_q));

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [ADDR_W-1:0]   addr,
  output logic [SAMPLE_W-1:0] data,
  output logic                valid
);

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int RST_CODE = dds_pkg::sine_code(0, ADDR_W, SAMPLE_W);

  logic [SAMPLE_W-1:0] table_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam int CODE = dds_pkg::sine_code(g, ADDR_W, SAMPLE_W);
    assign table_w[g] = CODE[SAMPLE_W-1:0];
  end

  logic [SAMPLE_W-1:0] data_q, data_d;
  logic                valid_q;

  always_comb begin
    data_d = data_q;
    if (en) data_d = table_w[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= RST_CODE[SAMPLE_W-1:0];
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= en;
    end
  end

  assign data  = data_q;
  assign valid = valid_q;

  assert_valid_follows_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> valid_q);

  assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!valid_q && $stable(data_q)));

endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen #(
  parameter int PHASE_W  = 12,
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_tick,
  input  logic [PHASE_W-1:0]  tune_word,
  input  logic                tune_load,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                sample_valid
);

  logic [PHASE_W-1:0] step_w;
  logic [ADDR_W-1:0]  addr_w;
  logic               adv_w;

  dds_tune_reg #(.PHASE_W(PHASE_W)) i_tune (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick),
    .load(tune_load), .word(tune_word), .step(step_w)
  );

  dds_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) i_acc (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .step(step_w),
    .addr(addr_w), .advanced(adv_w)
  );

  dds_sine_rom #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) i_rom (
    .clk(clk), .rst_n(rst_n), .en(adv_w), .addr(addr_w),
    .data(sample_out), .valid(sample_valid)
  );

  assert_valid_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(sample_tick, 2));

  assert_zero_step_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && step_w == '0) |=> ##1 $stable(sample_out));

endmodule

// File: tb/test_dds_sine_gen.sv
module test_dds_sine_gen;

  localparam int N = 12;
  localparam int P = 8;
  localparam int L = 10;
  localparam real PI_T = 3.14159265358979323846;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [N-1:0] word = '0;
  logic         load = 1'b0;
  logic [L-1:0] sample;
  logic         valid;

  int vectors = 0;
  int errs    = 0;

  logic [N-1:0] m_ph   = '0;
  logic [N-1:0] m_step = '0;
  logic [N-1:0] m_hold = '0;
  logic         m_hvld = 1'b0;

  always #2.5 clk = ~clk;

  dds_sine_gen #(.PHASE_W(N), .ADDR_W(P), .SAMPLE_W(L)) i_dds_sine_gen (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .tune_word(word),
    .tune_load(load), .sample_out(sample), .sample_valid(valid)
  );

  function automatic int expect_code(logic [N-1:0] ph);
    real v;
    int  r;
    int  a;
    a = int'(ph[N-1 -: P]);
    v = real'((1 << (L - 1)) - 1) * $sin(2.0 * PI_T * real'(a) / real'(1 << P));
    if (v >= 0.0) r = int'($rtoi(v + 0.5));
    else          r = -int'($rtoi(-v + 0.5));
    return (1 << (L - 1)) + r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  task automatic load_word(input logic [N-1:0] w);
    @(negedge clk); load = 1'b1; word = w;
    @(negedge clk); load = 1'b0;
    m_hold = w; m_hvld = 1'b1;
  endtask

  // one tick, then sample the result after the following edge
  task automatic do_tick(input string req);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    m_ph = m_ph + m_step;
    if (m_hvld) begin m_step = m_hold; m_hvld = 1'b0; end
    check(valid == 1'b0, "R4", int'(valid), 0);
    @(negedge clk);
    check(valid == 1'b1, "R4", int'(valid), 1);
    check(int'(sample) == expect_code(m_ph), req, int'(sample), expect_code(m_ph));
  endtask

  initial begin
    #1_000_000;
    vectors++; errs++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [L-1:0] held;
    logic [P-1:0] last_a;
    int           moves;
    repeat (3) @(negedge clk);
    check(int'(sample) == 512, "R1", int'(sample), 512);
    check(valid == 1'b0, "R1", int'(valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(int'(sample) == 512, "R1", int'(sample), 512);

    // R8: zero step from reset
    for (int i = 0; i < 3; i++) do_tick("R8");

    // R6: load 16; the next tick still adds 0
    load_word(12'd16);
    do_tick("R6");
    check(int'(sample) == 512, "R6", int'(sample), 512);

    // R3/R2: full table sweep with wrap
    for (int i = 0; i < 260; i++) do_tick("R3");

    // R5: no tick, hold
    held = sample;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(sample == held, "R5", int'(sample), int'(held));
      check(valid == 1'b0, "R5", int'(valid), 0);
    end

    // R9: step 1, address moves every 16 ticks
    load_word(12'd1);
    do_tick("R7");
    last_a = m_ph[N-1 -: P];
    moves = 0;
    for (int i = 0; i < 64; i++) begin
      do_tick("R9");
      if (m_ph[N-1 -: P] != last_a) moves++;
      last_a = m_ph[N-1 -: P];
    end
    check(moves == 4, "R9", moves, 4);

    // R7: odd step loaded mid-run, phase continues
    load_word(12'd333);
    for (int i = 0; i < 40; i++) do_tick("R7");

    // R2: aliasing step above half scale
    load_word(12'd2049);
    for (int i = 0; i < 300; i++) do_tick("R2");

    // R8: zero step loaded later
    load_word(12'd0);
    do_tick("R8");
    held = sample;
    for (int i = 0; i < 4; i++) begin
      do_tick("R8");
      check(sample == held, "R8", int'(sample), int'(held));
    end

    finish_run();
  end

endmodule